// File: doc/BRIEF.md
# Host Port Interface Slave

This block lets an external controller reach a word-wide on-chip memory through a narrow 8-bit parallel port. Two select lines pick one of three internal registers: a control register, an address register and a data register. A byte-phase line splits each 16-bit word into two byte transfers. Data-register accesses move words between the host and the memory. They can optionally step the address register by one, so a block of words needs only one address setup.

A second port, on the processor side, is a plain synchronous word port into the same memory. The memory has one access per cycle. When both sides want it in the same cycle the host goes first, and the processor sees a stall and must repeat its request. Two interrupt flags pass between the two sides: a host-to-processor request, and a processor-to-host request on an active-low output. Every host byte occupies the port for a fixed number of core cycles, and the ready output shows this.

The host bus is split into input, output and output-enable pins. The pad that combines them sits outside the block.

Top module: `hostport_slave`

## Requirements
- R1: The select lines `h_sel` choose the target: 2'b00 is the control register, 2'b10 is the address register, 2'b11 is the data register without address stepping, and 2'b01 is the data register with address stepping.
- R2: `h_phase` = 0 marks the first byte of a word and 1 marks the second. Control bit 0 sets the order: when it is 1 the first byte is bits 15:8, and when it is 0 the first byte is bits 7:0. This applies to address and data accesses.
- R3: With select 2'b01, the address register increments by one before a data write stores its word, and after the second byte of a data read. With select 2'b11 the address register is left unchanged.
- R4: On a host data write, the first byte is held in the data register. The second byte completes the word, which is then stored at the memory location given by the address register.
- R5: A control read returns {5'b0, hint flag, dspint flag, order bit} for either phase. Control writes act on the low byte alone, so sending the same byte twice is harmless.
- R6: A host control write with bit 1 set raises `p_int`. `p_int` stays high until `p_int_ack` is pulsed.
- R7: A pulse on `p_hint_set` drives `h_int_n` low. A host control write with bit 2 set returns it high. A control write with bit 2 clear leaves it low.
- R8: A host access begins on the falling edge of `h_stb_n`. The select, phase, direction and write byte are captured in that clock cycle.
- R9: `h_rdy` goes low in the cycle after the strobe edge and stays low for exactly BYTE_CYCLES (default 5) clock cycles. Strobe edges that arrive while it is low start nothing.
- R10: When the host and the processor request the memory in the same cycle, the host access is performed, `p_stall` is high in that cycle, and the processor write is not performed.
- R11: After reset, all registers and both interrupt flags are clear, `h_rdy` and `h_int_n` are high, and `p_int` is low.
- R12: An accepted processor read (`p_en` high, `p_we` low, `p_stall` low) presents the word on `p_rdata` one cycle later. An accepted processor write stores `p_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| h_stb_n | input | 1 | Host access strobe, active low; its falling edge starts an access |
| h_sel | input | 2 | Host register select |
| h_phase | input | 1 | Byte phase within a word |
| h_rnw | input | 1 | Host direction, 1 = read |
| hd_in | input | 8 | Host write byte |
| hd_out | output | 8 | Host read byte |
| hd_oe | output | 1 | Host bus drive enable during reads |
| h_rdy | output | 1 | High when the port can take a new byte |
| h_int_n | output | 1 | Interrupt to the host, active low |
| p_en | input | 1 | Processor memory request |
| p_we | input | 1 | Processor write enable |
| p_addr | input | ADDR_W | Processor word address |
| p_wdata | input | 16 | Processor write word |
| p_rdata | output | 16 | Processor read word |
| p_stall | output | 1 | Processor request not accepted this cycle |
| p_int | output | 1 | Interrupt request to the processor |
| p_int_ack | input | 1 | Clears the processor interrupt flag |
| p_hint_set | input | 1 | Raises the host interrupt flag |

## Verification
The hardest case to reach is a memory conflict. The processor request has to land in the single cycle when a host data write performs its memory access, and that is the first cycle of the busy window after the second byte's strobe edge. The bench waits for `h_rdy` to fall after that edge, drives a processor write to the same word in that cycle, and checks that the stall appears. It then reads the word back to confirm that the host data survived. A second strobe edge is also forced inside a busy window, and a read-back of the address register shows that the edge was ignored.

// File: rtl/hps_pkg.sv
package hps_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL     = 2'b00,
    SEL_DATA_INC = 2'b01,
    SEL_ADDR     = 2'b10,
    SEL_DATA     = 2'b11
  } hsel_e;

  localparam int CB_ORDER  = 0;
  localparam int CB_DSPINT = 1;
  localparam int CB_HINT   = 2;

  typedef struct packed {
    hsel_e      sel;
    logic       phase;
    logic       rnw;
    logic [7:0] wbyte;
  } hreq_t;

endpackage

// File: rtl/hps_host_seq.sv
module hps_host_seq
  import hps_pkg::*;
#(
  parameter int BYTE_CYCLES = 5,
  localparam int CW = (BYTE_CYCLES > 1) ? $clog2(BYTE_CYCLES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_n,
  input  hsel_e         sel,
  input  logic          phase,
  input  logic          rnw,
  input  logic [7:0]    din,
  output hreq_t         req,
  output logic          busy,
  output logic [CW-1:0] step,
  output logic          rdy
);

  logic stb_q;
  logic start;

  assign start = stb_q & ~stb_n & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= 1'b1;
      busy  <= 1'b0;
      step  <= '0;
      req   <= '0;
      rdy   <= 1'b1;
    end else begin
      stb_q <= stb_n;
      if (start) begin
        busy <= 1'b1;
        step <= '0;
        req  <= '{sel: sel, phase: phase, rnw: rnw, wbyte: din};
        rdy  <= 1'b0;
      end else if (busy) begin
        if (step == CW'(BYTE_CYCLES - 1)) begin
          busy <= 1'b0;
          rdy  <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  // R9: a captured edge drops ready on the next cycle
  p_ready_drop_r9: assert property (@(posedge clk) disable iff (rst)
    start |=> !rdy);

  // R9: within a busy window the captured request never changes
  p_single_access_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && step != CW'(BYTE_CYCLES - 1)) |=> (busy && $stable(req)));

endmodule

// File: rtl/hps_regs.sv
module hps_regs
  import hps_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  hreq_t             req,
  input  logic              busy,
  input  logic [CW-1:0]     step,
  input  logic [15:0]       ram_q,
  input  logic              p_int_ack,
  input  logic              p_hint_set,
  output logic              h_req,
  output logic              h_we,
  output logic [ADDR_W-1:0] h_addr,
  output logic [15:0]       h_wdata,
  output logic [7:0]        hd_out,
  output logic              hd_oe,
  output logic              p_int,
  output logic              h_int_n
);

  logic        order_q, dspint_q, hint_q;
  logic [15:0] addr_q, data_q, addr_nx;
  logic        exec0, exec1, exec2;
  logic        is_data, do_inc, hi_half;

  assign exec0   = busy && (step == CW'(0));
  assign exec1   = busy && (step == CW'(1));
  assign exec2   = busy && (step == CW'(2));
  assign is_data = req.sel[0];
  assign do_inc  = (req.sel == SEL_DATA_INC);
  assign hi_half = req.phase ^ order_q;
  assign addr_nx = addr_q + 16'd1;

  // memory request: word store on second written byte, fetch on first read byte
  assign h_req   = exec0 && is_data && (req.rnw ? !req.phase : req.phase);
  assign h_we    = !req.rnw;
  assign h_addr  = (do_inc && !req.rnw) ? addr_nx[ADDR_W-1:0] : addr_q[ADDR_W-1:0];
  assign h_wdata = hi_half ? {req.wbyte, data_q[7:0]} : {data_q[15:8], req.wbyte};

  assign p_int   = dspint_q;
  assign h_int_n = ~hint_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      order_q  <= 1'b0;
      dspint_q <= 1'b0;
      hint_q   <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      hd_out   <= '0;
      hd_oe    <= 1'b0;
    end else begin
      hd_oe <= busy && req.rnw;
      if (p_int_ack) dspint_q <= 1'b0;
      if (exec0 && !req.rnw) begin
        unique case (req.sel)
          SEL_CTRL: begin
            order_q <= req.wbyte[CB_ORDER];
            if (req.wbyte[CB_DSPINT]) dspint_q <= 1'b1;
            if (req.wbyte[CB_HINT])   hint_q   <= 1'b0;
          end
          SEL_ADDR: begin
            if (hi_half) addr_q[15:8] <= req.wbyte;
            else         addr_q[7:0]  <= req.wbyte;
          end
          default: begin
            if (hi_half) data_q[15:8] <= req.wbyte;
            else         data_q[7:0]  <= req.wbyte;
            if (req.phase && do_inc) addr_q <= addr_nx;
          end
        endcase
      end
      if (exec0 && req.rnw && is_data && req.phase && do_inc) addr_q <= addr_nx;
      if (exec1 && req.rnw && is_data && !req.phase) data_q <= ram_q;
      if (exec2 && req.rnw) begin
        unique case (req.sel)
          SEL_CTRL: hd_out <= {5'b0, hint_q, dspint_q, order_q};
          SEL_ADDR: hd_out <= hi_half ? addr_q[15:8] : addr_q[7:0];
          default:  hd_out <= hi_half ? data_q[15:8] : data_q[7:0];
        endcase
      end
      if (p_hint_set) hint_q <= 1'b1;
    end
  end

  // R3: stepping data accesses advance the address by one on the second byte
  p_autoinc_r3: assert property (@(posedge clk) disable iff (rst)
    (exec0 && do_inc && req.phase) |=> (addr_q == $past(addr_nx)));

  // R3: non-stepping data accesses leave the address alone
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (exec0 && req.sel == SEL_DATA) |=> $stable(addr_q));

  // R6: a control write with the request bit raises the processor interrupt
  p_dspint_set_r6: assert property (@(posedge clk) disable iff (rst)
    (exec0 && !req.rnw && req.sel == SEL_CTRL && req.wbyte[CB_DSPINT]) |=> p_int);

  // R7: processor-side set drives the host interrupt low
  p_hint_low_r7: assert property (@(posedge clk) disable iff (rst)
    p_hint_set |=> !h_int_n);

endmodule

// File: rtl/hps_wram.sv
module hps_wram #(
  parameter int ADDR_W = 10,
  parameter int DW     = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DW-1:0]     h_wdata,
  input  logic              p_en,
  input  logic              p_we,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [DW-1:0]     p_wdata,
  output logic [DW-1:0]     q,
  output logic              p_stall
);

  logic [DW-1:0]     mem [DEPTH];
  logic              en, we;
  logic [ADDR_W-1:0] a;
  logic [DW-1:0]     d;

  // host owns the single port whenever it asks
  always_comb begin
    en = h_req | p_en;
    we = h_req ? h_we : p_we;
    a  = h_req ? h_addr : p_addr;
    d  = h_req ? h_wdata : p_wdata;
  end

  assign p_stall = p_en & h_req;

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[a] <= d;
      q <= mem[a];
    end
  end

  // R10: a host write lands even when the processor asked in the same cycle
  p_host_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (h_req && h_we) |=> (mem[$past(h_addr)] == $past(h_wdata)));

  // R12: an accepted processor read returns the stored word next cycle
  p_proc_read_r12: assert property (@(posedge clk) disable iff (rst)
    (p_en && !p_we && !h_req) |=> (q == $past(mem[p_addr])));

endmodule

// File: rtl/hostport_slave.sv
module hostport_slave
  import hps_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int BYTE_CYCLES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_stb_n,
  input  logic [1:0]        h_sel,
  input  logic              h_phase,
  input  logic              h_rnw,
  input  logic [7:0]        hd_in,
  output logic [7:0]        hd_out,
  output logic              hd_oe,
  output logic              h_rdy,
  output logic              h_int_n,
  input  logic              p_en,
  input  logic              p_we,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [15:0]       p_wdata,
  output logic [15:0]       p_rdata,
  output logic              p_stall,
  output logic              p_int,
  input  logic              p_int_ack,
  input  logic              p_hint_set
);

  localparam int CW = (BYTE_CYCLES > 1) ? $clog2(BYTE_CYCLES) : 1;

  hreq_t             req;
  logic              busy;
  logic [CW-1:0]     step;
  logic              h_req, h_we;
  logic [ADDR_W-1:0] h_addr;
  logic [15:0]       h_wdata, ram_q;

  hps_host_seq #(.BYTE_CYCLES(BYTE_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .stb_n(h_stb_n), .sel(hsel_e'(h_sel)),
    .phase(h_phase), .rnw(h_rnw), .din(hd_in),
    .req(req), .busy(busy), .step(step), .rdy(h_rdy)
  );

  hps_regs #(.ADDR_W(ADDR_W), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .req(req), .busy(busy), .step(step),
    .ram_q(ram_q), .p_int_ack(p_int_ack), .p_hint_set(p_hint_set),
    .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .hd_out(hd_out), .hd_oe(hd_oe), .p_int(p_int), .h_int_n(h_int_n)
  );

  hps_wram #(.ADDR_W(ADDR_W), .DW(16)) u_wram (
    .clk(clk), .rst(rst), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .p_en(p_en), .p_we(p_we), .p_addr(p_addr),
    .p_wdata(p_wdata), .q(ram_q), .p_stall(p_stall)
  );

  assign p_rdata = ram_q;

endmodule

// File: tb/hostport_slave_bench.sv
`timescale 1ns/1ps
module hostport_slave_bench;

  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          h_stb_n = 1'b1;
  logic [1:0]    h_sel = 2'b00;
  logic          h_phase = 1'b0;
  logic          h_rnw = 1'b0;
  logic [7:0]    hd_in = 8'h00;
  logic [7:0]    hd_out;
  logic          hd_oe, h_rdy, h_int_n;
  logic          p_en = 1'b0, p_we = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [15:0]   p_wdata = '0;
  logic [15:0]   p_rdata;
  logic          p_stall, p_int;
  logic          p_int_ack = 1'b0, p_hint_set = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  int low_cnt;
  logic order_b = 1'b0;

  always #4 clk = ~clk;

  hostport_slave #(.ADDR_W(AW), .BYTE_CYCLES(5)) u_hostport_slave (
    .clk(clk), .rst(rst), .h_stb_n(h_stb_n), .h_sel(h_sel), .h_phase(h_phase),
    .h_rnw(h_rnw), .hd_in(hd_in), .hd_out(hd_out), .hd_oe(hd_oe), .h_rdy(h_rdy),
    .h_int_n(h_int_n), .p_en(p_en), .p_we(p_we), .p_addr(p_addr),
    .p_wdata(p_wdata), .p_rdata(p_rdata), .p_stall(p_stall), .p_int(p_int),
    .p_int_ack(p_int_ack), .p_hint_set(p_hint_set)
  );

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic host_byte(input logic [1:0] sel, input logic ph, input logic rd,
                           input logic [7:0] din, output logic [7:0] dout);
    @(negedge clk);
    h_sel = sel; h_phase = ph; h_rnw = rd; hd_in = din; h_stb_n = 1'b0;
    low_cnt = 0;
    @(negedge clk);
    while (!h_rdy && low_cnt < 50) begin
      low_cnt++;
      @(negedge clk);
    end
    dout = hd_out;
    h_stb_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ctrl_wr(input logic [7:0] v);
    logic [7:0] d;
    host_byte(2'b00, 1'b0, 1'b0, v, d);
    host_byte(2'b00, 1'b1, 1'b0, v, d);
    order_b = v[0];
  endtask

  task automatic word_wr(input logic [1:0] sel, input logic [15:0] w);
    logic [7:0] d;
    host_byte(sel, 1'b0, 1'b0, order_b ? w[15:8] : w[7:0], d);
    host_byte(sel, 1'b1, 1'b0, order_b ? w[7:0] : w[15:8], d);
  endtask

  task automatic word_rd(input logic [1:0] sel, output logic [15:0] w);
    logic [7:0] b0, b1;
    host_byte(sel, 1'b0, 1'b1, 8'h00, b0);
    host_byte(sel, 1'b1, 1'b1, 8'h00, b1);
    w = order_b ? {b0, b1} : {b1, b0};
  endtask

  task automatic proc_wr(input logic [AW-1:0] a, input logic [15:0] w);
    @(negedge clk);
    p_en = 1'b1; p_we = 1'b1; p_addr = a; p_wdata = w;
    @(negedge clk);
    p_en = 1'b0; p_we = 1'b0;
  endtask

  task automatic proc_rd(input logic [AW-1:0] a, output logic [15:0] w);
    @(negedge clk);
    p_en = 1'b1; p_we = 1'b0; p_addr = a;
    @(negedge clk);
    p_en = 1'b0;
    w = p_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R11 rdy", h_rdy, 1);
    check("R11 int_n", h_int_n, 1);
    check("R11 p_int", p_int, 0);
    host_byte(2'b00, 1'b0, 1'b1, 8'h00, d);
    check("R11 R5 ctrl", d, 8'h00);
    host_byte(2'b10, 1'b0, 1'b1, 8'h00, d);
    check("R11 addr", d, 8'h00);
  endtask

  task automatic t_write_plain();
    logic [15:0] w;
    word_wr(2'b10, 16'h0010);
    word_wr(2'b11, 16'h1234);
    proc_rd(10'h010, w);
    check("R4 R12 stored word", w, 16'h1234);
    word_rd(2'b10, w);
    check("R3 R1 addr held", w, 16'h0010);
  endtask

  task automatic t_autoinc_write();
    logic [15:0] w;
    word_wr(2'b01, 16'hBEEF);
    proc_rd(10'h011, w);
    check("R3 R1 preinc write", w, 16'hBEEF);
    word_rd(2'b10, w);
    check("R3 addr stepped", w, 16'h0011);
  endtask

  task automatic t_read_modes();
    logic [15:0] w;
    proc_wr(10'h040, 16'h7A5C);
    word_wr(2'b10, 16'h0040);
    word_rd(2'b11, w);
    check("R1 R2 plain read", w, 16'h7A5C);
    word_rd(2'b10, w);
    check("R3 addr after plain read", w, 16'h0040);
    word_rd(2'b01, w);
    check("R1 stepping read", w, 16'h7A5C);
    word_rd(2'b10, w);
    check("R3 addr postinc read", w, 16'h0041);
  endtask

  task automatic t_byte_order();
    logic [7:0] d;
    logic [15:0] w;
    ctrl_wr(8'h01);
    host_byte(2'b00, 1'b1, 1'b1, 8'h00, d);
    check("R5 ctrl order", d, 8'h01);
    word_wr(2'b10, 16'h0020);
    host_byte(2'b11, 1'b0, 1'b0, 8'hAB, d);
    host_byte(2'b11, 1'b1, 1'b0, 8'hCD, d);
    proc_rd(10'h020, w);
    check("R2 high first", w, 16'hABCD);
    host_byte(2'b10, 1'b0, 1'b1, 8'h00, d);
    check("R2 addr first byte high", d, 8'h00);
  endtask

  task automatic t_dspint();
    logic [7:0] d;
    ctrl_wr(8'h03);
    check("R6 p_int set", p_int, 1);
    host_byte(2'b00, 1'b0, 1'b1, 8'h00, d);
    check("R5 ctrl shows dspint", d, 8'h03);
    @(negedge clk); p_int_ack = 1'b1;
    @(negedge clk); p_int_ack = 1'b0;
    check("R6 p_int cleared", p_int, 0);
  endtask

  task automatic t_hint();
    logic [7:0] d;
    @(negedge clk); p_hint_set = 1'b1;
    @(negedge clk); p_hint_set = 1'b0;
    check("R7 int_n low", h_int_n, 0);
    host_byte(2'b00, 1'b0, 1'b1, 8'h00, d);
    check("R5 ctrl shows hint", d, 8'h05);
    ctrl_wr(8'h01);
    check("R7 zero write ignored", h_int_n, 0);
    ctrl_wr(8'h05);
    check("R7 int_n cleared", h_int_n, 1);
  endtask

  task automatic t_timing();
    logic [7:0] d;
    host_byte(2'b10, 1'b1, 1'b0, 8'h00, d);
    check("R9 busy length", low_cnt, 5);
    @(negedge clk);
    h_sel = 2'b10; h_phase = 1'b1; h_rnw = 1'b0; hd_in = 8'h5A; h_stb_n = 1'b0;
    @(negedge clk);
    @(negedge clk); h_stb_n = 1'b1;
    @(negedge clk); h_stb_n = 1'b0; hd_in = 8'hA5;
    while (!h_rdy) @(negedge clk);
    h_stb_n = 1'b1;
    @(negedge clk);
    host_byte(2'b10, 1'b1, 1'b1, 8'h00, d);
    check("R9 R8 extra edge ignored", d, 8'h5A);
  endtask

  task automatic t_conflict();
    logic [7:0] d;
    logic [15:0] w;
    word_wr(2'b10, 16'h0030);
    host_byte(2'b11, 1'b0, 1'b0, 8'h11, d);
    @(negedge clk);
    h_sel = 2'b11; h_phase = 1'b1; h_rnw = 1'b0; hd_in = 8'h22; h_stb_n = 1'b0;
    @(negedge clk);
    p_en = 1'b1; p_we = 1'b1; p_addr = 10'h030; p_wdata = 16'h5555;
    #1;
    check("R10 stall raised", p_stall, 1);
    @(negedge clk);
    p_en = 1'b0; p_we = 1'b0;
    while (!h_rdy) @(negedge clk);
    h_stb_n = 1'b1;
    @(negedge clk);
    proc_rd(10'h030, w);
    check("R10 host data kept", w, 16'h1122);
    proc_wr(10'h031, 16'h5555);
    proc_rd(10'h031, w);
    check("R12 retried write", w, 16'h5555);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_plain();
    t_autoinc_write();
    t_read_modes();
    t_byte_order();
    t_dspint();
    t_hint();
    t_timing();
    t_conflict();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule